// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing

This block buffers 9-bit words between two unrelated clock domains. A producer pushes words on the write clock with an active-low write strobe. A consumer pulls them on the read clock with an active-low read strobe. Pointers cross between the domains in Gray code through multi-stage synchronisers, so the two clocks need no fixed ratio or phase, and either clock may stop.

The read timing is chosen when the active-low master reset is released, and it stays fixed until the next reset. In standard timing, a word reaches the data output only when the consumer strobes a read. In fall-through timing, the oldest word is placed on the output without a strobe, and a strobe consumes it. The two main status pins change meaning with the timing. In standard timing they report empty and full. In fall-through timing they report a word present on the output and room for a write. Half-full, almost-empty and almost-full flags are valid in both timings, and an output enable can float the data bus.

Top module: `dm_fifo`

## Requirements
- R1: Words leave the FIFO in the order in which they were accepted, with no loss and no duplication, in both timings.
- R2: In standard timing (`mode_sel` = 0 at reset release), `dout` loads the oldest stored word only on a read-clock rising edge where `rd_en_n` is 0 and the FIFO is not empty. On any other edge `dout` holds its value, and after reset it is 0.
- R3: In fall-through timing (`mode_sel` = 1 at reset release), a word written into an empty FIFO is on `dout` with `out_stat` = 1 after the third read-clock rising edge that follows the write edge, and not after the second, with no read strobe. Each later word appears only after a read-clock edge with `rd_en_n` = 0 consumes the word already shown.
- R4: The level of `mode_sel` on the first read-clock and write-clock edges after `mrst_n` rises fixes the timing. Later changes of `mode_sel` have no effect until the next reset.
- R5: `out_stat` is 1 when the FIFO is empty in standard timing. In fall-through timing it is 1 when a valid word is on `dout`.
- R6: `in_stat` is 1 when DEPTH words are stored in standard timing. In fall-through timing it is 1 when a write would be accepted, which means fewer than DEPTH words are in the storage array.
- R7: `half_full` is 1 when the write-side count of words in the storage array exceeds DEPTH/2.
- R8: `almost_full` is 1 when DEPTH minus the write-side count is at most AF_OFS. `almost_empty` is 1 when the read-side count of words in the storage array is at most AE_OFS. A word already presented in fall-through timing does not count.
- R9: A write strobe while full and a read strobe while nothing is readable are ignored. No pointer moves, `dout` keeps its value, and the rejected word never appears.
- R10: When `oe_n` is 1, `dout` is high impedance. When it is 0, `dout` drives the held word.
- R11: While reset and right after it, the flags show an empty FIFO: `almost_empty` = 1, and `almost_full` = `half_full` = 0. In standard timing `out_stat` = 1 and `in_stat` = 0. In fall-through timing `out_stat` = 0 and `in_stat` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock, independent of wr_clk |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| mode_sel | input | 1 | Timing select latched at reset release: 0 standard, 1 fall-through |
| wr_en_n | input | 1 | Write strobe, active low |
| din | input | DATA_W | Write data |
| rd_en_n | input | 1 | Read strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | DATA_W | Read data, three-state |
| out_stat | output | 1 | Empty (standard) or output ready (fall-through) |
| in_stat | output | 1 | Full (standard) or input ready (fall-through) |
| half_full | output | 1 | More than DEPTH/2 words stored |
| almost_empty | output | 1 | Read-side count at or below AE_OFS |
| almost_full | output | 1 | Free space at or below AF_OFS |

## Verification
The bound checker watches several properties on every edge of the owning clock. No pointer moves on a rejected write or read. The output register holds without a strobe in standard timing, and a presented word holds in fall-through timing. A full FIFO always raises half-full and almost-full. The latched timing never changes after reset. Other behaviour can only be shown by the bench's scenarios: word order, the exact three-edge fall-through latency, the flag thresholds at their boundary counts, the changed meaning of the status pins after a reset in each timing, and the floating bus.

// File: rtl/dm_fifo_pkg.sv
package dm_fifo_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b = g;
        for (int s = 1; s < 32; s = s << 1) begin
            b = b ^ (b >> s);
        end
        return b;
    endfunction

endpackage

// File: rtl/dm_fifo_sync.sv
module dm_fifo_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dm_fifo_mem.sv
module dm_fifo_mem #(
    parameter int DATA_W = 9,
    parameter int AW     = 4
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge wr_clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/dm_fifo_wr_ctl.sv
module dm_fifo_wr_ctl
    import dm_fifo_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int AW     = 4,
    parameter int AF_OFS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_sel,
    input  logic          wr_en_n,
    input  logic [AW:0]   rgray_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic [AW:0]   wbin,
    output logic          full,
    output logic          in_stat,
    output logic          half_full,
    output logic          almost_full
);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic       run;
        fifo_mode_e mode;
        logic [AW:0] bin;
        logic [AW:0] gray;
    } wr_st_t;

    wr_st_t      st_d, st_q;
    fifo_mode_e  mode_eff;
    logic [AW:0] rbin, used, space;

    always_comb begin
        st_d     = st_q;
        st_d.run = 1'b1;
        if (!st_q.run) st_d.mode = fifo_mode_e'(mode_sel);
        mode_eff = st_q.run ? st_q.mode : fifo_mode_e'(mode_sel);

        rbin  = PW'(from_gray(32'(rgray_s)));
        used  = st_q.bin - rbin;
        space = PW'(DEPTH) - used;
        full  = (used == PW'(DEPTH));
        we    = !wr_en_n && !full;

        if (we) begin
            st_d.bin  = st_q.bin + PW'(1);
            st_d.gray = PW'(to_gray(32'(st_d.bin)));
        end

        in_stat     = (mode_eff == MODE_FWFT) ? !full : full;
        half_full   = (used > PW'(DEPTH / 2));
        almost_full = (space <= PW'(AF_OFS));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign waddr = st_q.bin[AW-1:0];
    assign wgray = st_q.gray;
    assign wbin  = st_q.bin;
endmodule

// File: rtl/dm_fifo_rd_ctl.sv
module dm_fifo_rd_ctl
    import dm_fifo_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int AW     = 4,
    parameter int AE_OFS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              rd_en_n,
    input  logic [AW:0]       wgray_s,
    input  logic [DATA_W-1:0] rdata,
    output logic [AW-1:0]     raddr,
    output logic [AW:0]       rgray,
    output logic [AW:0]       rbin,
    output logic [DATA_W-1:0] dout_q,
    output logic              out_valid,
    output logic              mode_fwft,
    output logic              ram_empty,
    output logic              out_stat,
    output logic              almost_empty
);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic              run;
        fifo_mode_e        mode;
        logic [AW:0]       bin;
        logic [AW:0]       gray;
        logic [DATA_W-1:0] dout;
        logic              ov;
    } rd_st_t;

    rd_st_t      st_d, st_q;
    fifo_mode_e  mode_eff;
    logic [AW:0] wbin, held;
    logic        consume, load;

    always_comb begin
        st_d     = st_q;
        st_d.run = 1'b1;
        if (!st_q.run) st_d.mode = fifo_mode_e'(mode_sel);
        mode_eff = st_q.run ? st_q.mode : fifo_mode_e'(mode_sel);

        wbin      = PW'(from_gray(32'(wgray_s)));
        held      = wbin - st_q.bin;
        ram_empty = (held == '0);
        consume   = st_q.ov && !rd_en_n;

        if (mode_eff == MODE_FWFT) load = !ram_empty && (!st_q.ov || consume);
        else                       load = !rd_en_n && !ram_empty;

        if (load) begin
            st_d.dout = rdata;
            st_d.bin  = st_q.bin + PW'(1);
            st_d.gray = PW'(to_gray(32'(st_d.bin)));
            st_d.ov   = (mode_eff == MODE_FWFT);
        end else if (consume) begin
            st_d.ov = 1'b0;
        end

        out_stat     = (mode_eff == MODE_FWFT) ? st_q.ov : ram_empty;
        almost_empty = (held <= PW'(AE_OFS));
        mode_fwft    = (mode_eff == MODE_FWFT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raddr     = st_q.bin[AW-1:0];
    assign rgray     = st_q.gray;
    assign rbin      = st_q.bin;
    assign dout_q    = st_q.dout;
    assign out_valid = st_q.ov;
endmodule

// File: rtl/dm_fifo.sv
module dm_fifo #(
    parameter int DATA_W      = 9,
    parameter int DEPTH       = 16,
    parameter int AE_OFS      = 2,
    parameter int AF_OFS      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              mrst_n,
    input  logic              mode_sel,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_en_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              out_stat,
    output logic              in_stat,
    output logic              half_full,
    output logic              almost_empty,
    output logic              almost_full
);
    localparam int AW = $clog2(DEPTH);

    logic              we, full_w, ram_empty_r, out_valid_r, mode_fwft_r;
    logic [AW-1:0]     waddr, raddr;
    logic [AW:0]       wgray, rgray, wgray_s, rgray_s, wr_ptr_bin, rd_ptr_bin;
    logic [DATA_W-1:0] rdata, dout_r;

    dm_fifo_mem #(.DATA_W(DATA_W), .AW(AW)) u_mem (
        .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(din),
        .raddr(raddr), .rdata(rdata)
    );

    dm_fifo_sync #(.W(AW + 1), .STAGES(SYNC_STAGES)) u_sync_w2r (
        .clk(rd_clk), .rst_n(mrst_n), .d(wgray), .q(wgray_s)
    );

    dm_fifo_sync #(.W(AW + 1), .STAGES(SYNC_STAGES)) u_sync_r2w (
        .clk(wr_clk), .rst_n(mrst_n), .d(rgray), .q(rgray_s)
    );

    dm_fifo_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .AF_OFS(AF_OFS)) u_wr (
        .clk(wr_clk), .rst_n(mrst_n), .mode_sel(mode_sel), .wr_en_n(wr_en_n),
        .rgray_s(rgray_s), .we(we), .waddr(waddr), .wgray(wgray),
        .wbin(wr_ptr_bin), .full(full_w), .in_stat(in_stat),
        .half_full(half_full), .almost_full(almost_full)
    );

    dm_fifo_rd_ctl #(.DATA_W(DATA_W), .AW(AW), .AE_OFS(AE_OFS)) u_rd (
        .clk(rd_clk), .rst_n(mrst_n), .mode_sel(mode_sel), .rd_en_n(rd_en_n),
        .wgray_s(wgray_s), .rdata(rdata), .raddr(raddr), .rgray(rgray),
        .rbin(rd_ptr_bin), .dout_q(dout_r), .out_valid(out_valid_r),
        .mode_fwft(mode_fwft_r), .ram_empty(ram_empty_r),
        .out_stat(out_stat), .almost_empty(almost_empty)
    );

    assign dout = oe_n ? {DATA_W{1'bz}} : dout_r;
endmodule

// File: rtl/dm_fifo_chk.sv
module dm_fifo_chk #(
    parameter int PW     = 5,
    parameter int DATA_W = 9
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              mrst_n,
    input logic              wr_en_n,
    input logic              rd_en_n,
    input logic              full_w,
    input logic              half_full,
    input logic              almost_full,
    input logic              ram_empty_r,
    input logic              out_valid_r,
    input logic              mode_fwft_r,
    input logic [PW-1:0]     wr_ptr_bin,
    input logic [PW-1:0]     rd_ptr_bin,
    input logic [DATA_W-1:0] dout_r
);
    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        (full_w && !wr_en_n) |=> $stable(wr_ptr_bin)); // R9

    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        ram_empty_r |=> $stable(rd_ptr_bin)); // R9

    AST_FULL_HALF: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        full_w |-> half_full); // R7

    AST_FULL_ALMOST: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        full_w |-> almost_full); // R8

    AST_STD_HOLD: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        (!mode_fwft_r && rd_en_n) |=> $stable(dout_r)); // R2

    AST_FWFT_HOLD: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        (mode_fwft_r && out_valid_r && rd_en_n) |=> (out_valid_r && $stable(dout_r))); // R3

    AST_MODE_LATCH: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        $past(mrst_n) |-> $stable(mode_fwft_r)); // R4
endmodule

bind dm_fifo dm_fifo_chk #(.PW(AW + 1), .DATA_W(DATA_W)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .wr_en_n(wr_en_n),
    .rd_en_n(rd_en_n), .full_w(full_w), .half_full(half_full),
    .almost_full(almost_full), .ram_empty_r(ram_empty_r),
    .out_valid_r(out_valid_r), .mode_fwft_r(mode_fwft_r),
    .wr_ptr_bin(wr_ptr_bin), .rd_ptr_bin(rd_ptr_bin), .dout_r(dout_r)
);

// File: tb/dm_fifo_tb.sv
module dm_fifo_tb;
    logic       wr_clk, rd_clk, mrst_n, mode_sel, wr_en_n, rd_en_n, oe_n;
    logic [8:0] din;
    wire  [8:0] dout;
    logic       out_stat, in_stat, half_full, almost_empty, almost_full;

    int         checks = 0;
    int         errors = 0;
    int         rd_edges = 0;
    bit         done = 0;
    logic [8:0] exp_q[$];
    logic [8:0] last_word;

    dm_fifo u_dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .mode_sel(mode_sel),
        .wr_en_n(wr_en_n), .din(din), .rd_en_n(rd_en_n), .oe_n(oe_n),
        .dout(dout), .out_stat(out_stat), .in_stat(in_stat),
        .half_full(half_full), .almost_empty(almost_empty), .almost_full(almost_full)
    );

    initial begin
        wr_clk = 1'b0;
        forever #4 wr_clk = ~wr_clk;
    end

    initial begin
        rd_clk = 1'b0;
        #3;
        forever #6 rd_clk = ~rd_clk;
    end

    always @(posedge rd_clk) rd_edges++;

    task automatic chk(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit m);
        mrst_n = 1'b0; mode_sel = m; wr_en_n = 1'b1; rd_en_n = 1'b1; oe_n = 1'b0; din = '0;
        exp_q.delete();
        repeat (3) @(posedge rd_clk);
        @(negedge wr_clk) mrst_n = 1'b1;
        repeat (3) @(posedge rd_clk);
        repeat (3) @(posedge wr_clk);
        mode_sel = ~m;
    endtask

    task automatic wr_word(input logic [8:0] v, input bit accept);
        @(negedge wr_clk);
        din = v; wr_en_n = 1'b0;
        @(posedge wr_clk);
        #1 wr_en_n = 1'b1;
        if (accept) exp_q.push_back(v);
    endtask

    task automatic rd_cyc(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    task automatic rd_std(input string req);
        logic [8:0] e;
        @(negedge rd_clk) rd_en_n = 1'b0;
        @(negedge rd_clk) rd_en_n = 1'b1;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            last_word = e;
            chk(dout === e, req, dout, e);
        end
    endtask

    task automatic rd_fwft(input string req);
        logic [8:0] e;
        @(negedge rd_clk);
        for (int i = 0; i < 12 && out_stat !== 1'b1; i++) @(negedge rd_clk);
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 9'h000;
        last_word = e;
        chk(out_stat === 1'b1 && dout === e, req, dout, e);
        rd_en_n = 1'b0;
        @(negedge rd_clk) rd_en_n = 1'b1;
    endtask

    initial begin
        #500000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        logic [8:0] v;
        // ---------------- standard timing ----------------
        do_reset(1'b0);
        @(negedge rd_clk);
        chk(out_stat == 1'b1, "R11 std empty", out_stat, 1);
        chk(in_stat == 1'b0, "R11 std full", in_stat, 0);
        chk(almost_empty == 1'b1 && almost_full == 1'b0 && half_full == 1'b0,
            "R11 level flags", {almost_empty, almost_full, half_full}, 9'b100);
        wr_word(9'h1A5, 1'b1);
        rd_cyc(6);
        chk(out_stat == 1'b0, "R5 not empty", out_stat, 0);
        chk(dout !== 9'h1A5, "R2 no strobe no data", dout, 0);
        rd_std("R2 strobed read");
        rd_cyc(1);
        chk(out_stat == 1'b1, "R5 empty again", out_stat, 1);
        @(negedge rd_clk) rd_en_n = 1'b0;
        @(negedge rd_clk) rd_en_n = 1'b1;
        chk(dout === 9'h1A5, "R9 read while empty", dout, 9'h1A5);
        rd_cyc(4);
        for (int i = 0; i < 16; i++) begin
            v = 9'((i * 37 + 11) % 512);
            wr_word(v, 1'b1);
            if (i == 7)  chk(half_full == 1'b0, "R7 count 8", half_full, 0);
            if (i == 8)  chk(half_full == 1'b1, "R7 count 9", half_full, 1);
            if (i == 12) chk(almost_full == 1'b0, "R8 count 13", almost_full, 0);
            if (i == 13) chk(almost_full == 1'b1, "R8 count 14", almost_full, 1);
            if (i == 15) chk(in_stat == 1'b1, "R6 std full", in_stat, 1);
        end
        wr_word(9'h0FF, 1'b0);
        chk(in_stat == 1'b1, "R9 write while full", in_stat, 1);
        rd_cyc(4);
        for (int i = 0; i < 16; i++) begin
            rd_std("R1 std order");
            chk(almost_empty == ((15 - i) <= 2), "R8 almost empty",
                almost_empty, ((15 - i) <= 2));
        end
        rd_cyc(2);
        chk(out_stat == 1'b1, "R9 rejected word absent", out_stat, 1);
        oe_n = 1'b1;
        #1 chk(dout !== last_word, "R10 floated", dout, 9'h000);
        oe_n = 1'b0;
        #1 chk(dout === last_word, "R10 driven", dout, last_word);

        // ---------------- fall-through timing ----------------
        do_reset(1'b1);
        @(negedge rd_clk);
        chk(out_stat == 1'b0, "R11 fwft not ready", out_stat, 0);
        chk(in_stat == 1'b1, "R11 fwft input ready", in_stat, 1);
        @(negedge wr_clk);
        din = 9'h155; wr_en_n = 1'b0;
        @(posedge wr_clk);
        base = rd_edges;
        exp_q.push_back(9'h155);
        #1 wr_en_n = 1'b1;
        wait (rd_edges == base + 2);
        #1 chk(out_stat == 1'b0, "R3 not after two edges", out_stat, 0);
        wait (rd_edges == base + 3);
        #1 chk(out_stat == 1'b1 && dout === 9'h155, "R3 after three edges", dout, 9'h155);
        chk(out_stat == 1'b1, "R4 mode held after mode_sel change", out_stat, 1);
        wr_word(9'h0AA, 1'b1);
        rd_cyc(6);
        chk(dout === 9'h155, "R3 later word waits", dout, 9'h155);
        rd_fwft("R3 first consume");
        rd_fwft("R1 fwft order");
        rd_cyc(1);
        chk(out_stat == 1'b0, "R5 fwft drained", out_stat, 0);
        @(negedge rd_clk) rd_en_n = 1'b0;
        rd_cyc(3);
        rd_en_n = 1'b1;
        chk(dout === 9'h0AA && out_stat == 1'b0, "R9 read while not ready", dout, 9'h0AA);
        for (int i = 0; i < 16; i++) begin
            wr_word(9'((i * 53 + 7) % 512), 1'b1);
        end
        rd_cyc(10);
        chk(in_stat == 1'b1, "R6 room left", in_stat, 1);
        wr_word(9'h1C3, 1'b1);
        chk(in_stat == 1'b0, "R6 fwft no room", in_stat, 0);
        wr_word(9'h0FF, 1'b0);
        chk(in_stat == 1'b0, "R9 fwft write while full", in_stat, 0);
        for (int i = 0; i < 17; i++) rd_fwft("R1 fwft drain");
        rd_cyc(2);
        chk(out_stat == 1'b0, "R5 fwft empty at end", out_stat, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule